// File: doc/BRIEF.md
# Multi-Channel Phase-Offset PWM Generator

This block drives a bank of PWM channels from one shared period counter. The counter runs from 0 to `top-1` and moves one step on each cycle where `tick` is high, so an external prescaler sets the tick rate. Each channel has three settings: a pulse width (`level`), a start tick (`offset`) and a polarity bit. Each channel also has an output position that routes its pulse to any bit of the 32-bit `pwm_out` word.

A pulse that starts late in a period and runs past `top` is not cut off. The rest of it carries into the next period, so that period opens with the channel active. The channel then goes inactive at the wrapped end tick.

Software writes settings into a shadow bank. It writes one channel record per `wr_en` pulse, and writes the period through `top_wr`. A `load` pulse arms a commit. The shadow bank moves into the active bank on the edge where the counter wraps, so a running period is never changed part way. All pins are plain control pins. Writes are accepted on every cycle and the block never applies back-pressure.

Top module: `phase_pwm_bank`

## Requirements
- R1: The counter starts at 0 after reset. It advances by one only on cycles with `tick` high. On a tick at `top-1` it returns to 0, and that edge is the period boundary.
- R2: Suppose `level>0`, `offset<top` and `level<top`. Then the channel is active while the counter is at least `offset` and below `offset+level`.
- R3: Suppose the active settings give `offset+level>top`, with `level<top` and `offset<top`. Then in the next period the channel is also active while the counter is below `offset+level-top`. That carry is computed from the settings and top that were in force during the period that overran.
- R4: A channel with `level==0`, or with `offset>=top`, starts no pulse in that period.
- R5: A channel with `level>=top` is active for the whole period.
- R6: When `pol` is 1, the channel's output bit is inverted. Its idle level becomes 1 and its active level becomes 0.
- R7: A `top_val` of 0 is stored as 1. Top is a 16-bit value, so it can be at most 65535.
- R8: Each channel's bit goes to position `pin` (0..31) of `pwm_out`. Channels that share a position are ORed together. Positions that no channel selects read 0.
- R9: Shadow writes have no effect on the outputs until a `load` pulse. A commit happens on the first period boundary at or after that pulse. At that edge the shadow content held before the edge, including top, becomes active.
- R10: Synchronous reset clears `pwm_out` to 0. It also sets every channel to level 0, offset 0, polarity 0 and pin equal to the channel index, and sets top to `DEF_TOP`.
- R11: `pwm_out` is registered. The value seen after a clock edge reflects the counter and active settings that were present before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Counter advance enable from the prescaler |
| wr_en | input | 1 | Write one channel record into the shadow bank |
| wr_ch | input | CH_W | Channel index for the write |
| wr_level | input | 16 | Pulse width in ticks |
| wr_offset | input | 16 | Start tick of the pulse |
| wr_pol | input | 1 | Output inversion |
| wr_pin | input | 5 | Output bit position |
| top_wr | input | 1 | Write the shadow period value |
| top_val | input | 16 | Period length in ticks (0 is stored as 1) |
| load | input | 1 | Arm a commit at the next period boundary |
| pwm_out | output | 32 | Routed PWM output word |

## Verification
Every result appears at `pwm_out` exactly one clock after the counter state that caused it. This is because only the output register lies between the counter and the pins. A committed configuration shows first in the cycle after the wrap edge, and carried pulses show from the first cycle of the new period. The bench keeps a behavioural model that it advances on each rising edge, using the same inputs the design sees. It compares the model's prediction with `pwm_out` at the falling edge that follows, so every comparison falls in the cycle where the result is due.

// File: rtl/phase_pwm_pkg.sv
package phase_pwm_pkg;
  localparam int CNT_W = 16;
  localparam int OUT_W = 32;
  localparam int PIN_W = $clog2(OUT_W);

  typedef struct packed {
    logic [CNT_W-1:0] level;
    logic [CNT_W-1:0] offset;
    logic             pol;
    logic [PIN_W-1:0] pin;
  } chan_cfg_t;
endpackage

// File: rtl/phase_pwm_counter.sv
module phase_pwm_counter
  import phase_pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] top_a,
  output logic [CNT_W-1:0] cnt,
  output logic             bnd
);
  assign bnd = tick && (cnt == CNT_W'(top_a - 1'b1));

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (bnd)  cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  assert_cnt_below_top_R1: assert property (@(posedge clk) disable iff (rst)
    cnt < top_a);
  assert_hold_without_tick_R1: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));
endmodule

// File: rtl/phase_pwm_regs.sv
module phase_pwm_regs
  import phase_pwm_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int DEF_TOP = 20,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CH_W-1:0]  wr_ch,
  input  chan_cfg_t        wr_cfg,
  input  logic             top_wr,
  input  logic [CNT_W-1:0] top_val,
  input  logic             load,
  input  logic             bnd,
  output chan_cfg_t        act_cfg [NUM_CH],
  output logic [CNT_W-1:0] top_a
);
  chan_cfg_t        sh_cfg [NUM_CH];
  logic [CNT_W-1:0] top_s;
  logic             pending;
  logic             commit;

  assign commit = bnd && (pending || load);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CH; i++) begin
        sh_cfg[i]  <= '{level: '0, offset: '0, pol: 1'b0, pin: PIN_W'(i)};
        act_cfg[i] <= '{level: '0, offset: '0, pol: 1'b0, pin: PIN_W'(i)};
      end
      top_s   <= CNT_W'(DEF_TOP);
      top_a   <= CNT_W'(DEF_TOP);
      pending <= 1'b0;
    end else begin
      if (wr_en && (32'(wr_ch) < NUM_CH)) sh_cfg[wr_ch] <= wr_cfg;
      if (top_wr) top_s <= (top_val == '0) ? CNT_W'(1) : top_val;
      if (commit) begin
        for (int i = 0; i < NUM_CH; i++) act_cfg[i] <= sh_cfg[i];
        top_a <= top_s;
      end
      pending <= bnd ? 1'b0 : (pending || load);
    end
  end

  assert_top_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
    top_a != '0);
  assert_top_moves_at_boundary_R9: assert property (@(posedge clk) disable iff (rst)
    !bnd |=> $stable(top_a));
  assert_pending_cleared_R9: assert property (@(posedge clk) disable iff (rst)
    bnd |=> !pending);
endmodule

// File: rtl/phase_pwm_chan.sv
module phase_pwm_chan
  import phase_pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bnd,
  input  logic [CNT_W-1:0] level,
  input  logic [CNT_W-1:0] offset,
  input  logic             pol,
  input  logic [CNT_W-1:0] top_a,
  input  logic [CNT_W-1:0] cnt,
  output logic             lvl
);
  logic [CNT_W:0]   endp;
  logic [CNT_W-1:0] carry, carry_nx;
  logic             full, starts, in_main, in_carry;

  assign endp     = {1'b0, offset} + {1'b0, level};
  assign full     = (level >= top_a);
  assign starts   = (level != '0) && (offset < top_a);
  assign in_main  = starts && (cnt >= offset) && ({1'b0, cnt} < endp);
  assign in_carry = (cnt < carry);
  assign lvl      = (full || in_main || in_carry) ^ pol;

  always_comb begin
    carry_nx = '0;
    if (starts && !full && (endp > {1'b0, top_a}))
      carry_nx = CNT_W'(endp - {1'b0, top_a});
  end

  always_ff @(posedge clk) begin
    if (rst)      carry <= '0;
    else if (bnd) carry <= carry_nx;
  end

  assert_carry_only_at_boundary_R3: assert property (@(posedge clk) disable iff (rst)
    !bnd |=> $stable(carry));
endmodule

// File: rtl/phase_pwm_bank.sv
module phase_pwm_bank
  import phase_pwm_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int DEF_TOP = 20,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [CH_W-1:0]  wr_ch,
  input  logic [CNT_W-1:0] wr_level,
  input  logic [CNT_W-1:0] wr_offset,
  input  logic             wr_pol,
  input  logic [PIN_W-1:0] wr_pin,
  input  logic             top_wr,
  input  logic [CNT_W-1:0] top_val,
  input  logic             load,
  output logic [OUT_W-1:0] pwm_out
);
  chan_cfg_t        act_cfg [NUM_CH];
  chan_cfg_t        wr_cfg;
  logic [CNT_W-1:0] top_a, cnt;
  logic             bnd;
  logic [NUM_CH-1:0] ch_lvl;
  logic [OUT_W-1:0] out_nx;

  assign wr_cfg = '{level: wr_level, offset: wr_offset, pol: wr_pol, pin: wr_pin};

  phase_pwm_counter u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .top_a(top_a), .cnt(cnt), .bnd(bnd)
  );

  phase_pwm_regs #(.NUM_CH(NUM_CH), .DEF_TOP(DEF_TOP)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_cfg(wr_cfg),
    .top_wr(top_wr), .top_val(top_val), .load(load), .bnd(bnd),
    .act_cfg(act_cfg), .top_a(top_a)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    phase_pwm_chan u_chan (
      .clk(clk), .rst(rst), .bnd(bnd),
      .level(act_cfg[c].level), .offset(act_cfg[c].offset), .pol(act_cfg[c].pol),
      .top_a(top_a), .cnt(cnt), .lvl(ch_lvl[c])
    );
  end

  always_comb begin
    out_nx = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (ch_lvl[c]) out_nx[act_cfg[c].pin] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_out <= '0;
    else     pwm_out <= out_nx;
  end
endmodule

// File: tb/test_phase_pwm_bank.sv
module test_phase_pwm_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int DTOP = 20;

  logic clk = 0, rst = 1, tick = 0, wr_en = 0, wr_pol = 0, top_wr = 0, load = 0;
  logic [2:0]  wr_ch = 0;
  logic [15:0] wr_level = 0, wr_offset = 0, top_val = 0;
  logic [4:0]  wr_pin = 0;
  logic [31:0] pwm_out;

  int checks = 0, errors = 0, cycles = 0, tick_mode = 0;
  string cur_req = "R10";
  bit started = 0;

  // behavioural model
  int m_cnt, m_top, s_top, m_pend;
  int a_lv[NCH], a_of[NCH], a_po[NCH], a_pn[NCH], m_car[NCH];
  int s_lv[NCH], s_of[NCH], s_po[NCH], s_pn[NCH];
  logic [31:0] exp_out;

  phase_pwm_bank #(.NUM_CH(NCH), .DEF_TOP(DTOP)) i_phase_pwm_bank (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_ch(wr_ch),
    .wr_level(wr_level), .wr_offset(wr_offset), .wr_pol(wr_pol), .wr_pin(wr_pin),
    .top_wr(top_wr), .top_val(top_val), .load(load), .pwm_out(pwm_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit ch_active(int c);
    int e;
    e = a_of[c] + a_lv[c];
    if (a_lv[c] >= m_top) return 1;
    if (m_cnt < m_car[c]) return 1;
    if (a_lv[c] > 0 && a_of[c] < m_top && m_cnt >= a_of[c] && m_cnt < e) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_top = DTOP; s_top = DTOP; m_pend = 0; exp_out = '0;
      for (int c = 0; c < NCH; c++) begin
        a_lv[c] = 0; a_of[c] = 0; a_po[c] = 0; a_pn[c] = c; m_car[c] = 0;
        s_lv[c] = 0; s_of[c] = 0; s_po[c] = 0; s_pn[c] = c;
      end
    end else begin
      bit bnd;
      exp_out = '0;
      for (int c = 0; c < NCH; c++)
        if (ch_active(c) != a_po[c][0]) exp_out[a_pn[c]] = 1'b1;
      bnd = tick && (m_cnt == m_top - 1);
      if (bnd) begin
        for (int c = 0; c < NCH; c++) begin
          int e;
          e = a_of[c] + a_lv[c];
          m_car[c] = (a_lv[c] > 0 && a_lv[c] < m_top && a_of[c] < m_top && e > m_top)
                     ? e - m_top : 0;
        end
        if (m_pend != 0 || load) begin
          for (int c = 0; c < NCH; c++) begin
            a_lv[c] = s_lv[c]; a_of[c] = s_of[c]; a_po[c] = s_po[c]; a_pn[c] = s_pn[c];
          end
          m_top = s_top;
        end
        m_pend = 0;
        m_cnt = 0;
      end else begin
        if (load) m_pend = 1;
        if (tick) m_cnt++;
      end
      if (wr_en) begin
        s_lv[wr_ch] = wr_level; s_of[wr_ch] = wr_offset;
        s_po[wr_ch] = wr_pol; s_pn[wr_ch] = wr_pin;
      end
      if (top_wr) s_top = (top_val == 0) ? 1 : top_val;
    end
    started = 1;
  end

  always @(negedge clk) begin
    cycles++;
    if (started) begin
      checks++;
      if (pwm_out !== exp_out) begin
        errors++;
        $display("FAIL %s: pwm_out=%h expected %h (cycle %0d)", cur_req, pwm_out, exp_out, cycles);
      end
    end
    case (tick_mode)
      0: tick <= 1'b1;
      1: tick <= (cycles % 3) != 0;
      default: tick <= 1'b0;
    endcase
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int ch, int lv, int of, int po, int pn);
    @(negedge clk);
    wr_en <= 1; wr_ch <= 3'(ch); wr_level <= 16'(lv); wr_offset <= 16'(of);
    wr_pol <= po[0]; wr_pin <= 5'(pn);
    @(negedge clk);
    wr_en <= 0;
  endtask

  task automatic set_top(int v);
    @(negedge clk); top_wr <= 1; top_val <= 16'(v);
    @(negedge clk); top_wr <= 0;
  endtask

  task automatic do_load();
    @(negedge clk); load <= 1;
    @(negedge clk); load <= 0;
  endtask

  initial begin
    // R10: reset state held for a few cycles, then idle outputs with defaults
    step(3);
    @(negedge clk); rst <= 0;
    cur_req = "R10"; step(25);
    // R9: shadow writes without load must not reach pwm_out
    cur_req = "R9";
    wr(0, 5, 2, 0, 0);
    wr(1, 6, 17, 0, 3);
    step(45);
    // R2 and R3: commit, then in-period pulse and wrapped carry
    do_load();
    cur_req = "R3"; step(70);
    cur_req = "R2"; step(20);
    // R4 zero level / offset past top, R5 full period, R6 inversion, R8 shared and high bit
    wr(2, 0, 4, 0, 2);
    wr(3, 4, 25, 0, 4);
    wr(4, 30, 7, 0, 5);
    wr(5, 3, 0, 1, 6);
    wr(6, 2, 10, 0, 3);
    wr(7, 4, 12, 0, 31);
    do_load();
    cur_req = "R4"; step(30);
    cur_req = "R5"; step(20);
    cur_req = "R6"; step(20);
    cur_req = "R8"; step(30);
    // R1 and R11: irregular tick pattern, then ticks stopped
    tick_mode = 1; cur_req = "R1"; step(120);
    tick_mode = 2; cur_req = "R11"; step(15);
    tick_mode = 0;
    // R7: top of zero clamped to one; then a small top with carry
    set_top(0); do_load();
    cur_req = "R7"; step(60);
    set_top(9); wr(0, 5, 7, 0, 0); do_load();
    cur_req = "R3"; step(60);
    // R3: carry computed from old settings survives a commit that removes the pulse
    wr(0, 0, 0, 0, 0); do_load();
    cur_req = "R3"; step(40);
    // R10: reset mid-run restores idle outputs and default settings
    @(negedge clk); rst <= 1;
    cur_req = "R10"; step(3);
    @(negedge clk); rst <= 0;
    step(30);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule